// File: doc/BRIEF.md
# Two-Plane Alpha Blend Colour-Key Compositor

This block merges one graphics pixel and one video-overlay pixel into a single RGB888 pixel on every valid cycle. Both inputs arrive already widened to 8-bit ARGB, with the alpha in bits 31:24 and red, green and blue in bits 23:16, 15:8 and 7:0. Each plane has its own settings: how its alpha is chosen, a global alpha value, a colour key, a key mask and the colour the key is compared against. A plane-order setting decides which plane lies underneath. The bottom plane is first blended over a black background. The top plane is then blended over that result.

All settings are held in shadow registers. The settings presented on the configuration inputs take effect only when a frame-start pulse arrives. The pixel presented in the same cycle as the pulse already uses the new settings, so a whole frame is always composed with one consistent set. The block has two register stages: the bottom-over-background blend, then the top-over-bottom blend.

Top module: `plane_compositor`

## Requirements
- R1: In reset, `out_valid` and `out_rgb` are 0. After reset the active settings are: video on top, graphics at the bottom, both planes in blend mode 0 (opaque) and keying off. The output therefore equals the video pixel's RGB.
- R2: `out_valid` equals `in_valid` from two clock cycles earlier. `out_rgb` belongs to that same pixel.
- R3: Blend-mode code 0, and the unused code 3, make a plane opaque. Its alpha is 255.
- R4: Blend-mode code 1 uses the plane's 8-bit global alpha setting as the alpha.
- R5: Blend-mode code 2 uses the pixel's own bits 31:24 as the alpha.
- R6: Each channel is computed as out = (a*upper + (255-a)*lower + 127)/255, with integer division. The bottom plane is blended over black (0). The top plane is blended over the bottom result.
- R7: Key-source code 2 compares the plane's own pixel RGB with its key. On a match the plane's alpha becomes 0.
- R8: Key-source code 1 compares the RGB of the layer beneath with the key. For the top plane, that is the bottom plane's raw pixel RGB. For the bottom plane, it is black (0). On a match the alpha becomes 0. Codes 0 and 3 disable keying.
- R9: Only the bits set in a plane's 24-bit key mask take part in the key comparison. A mask of zero matches every colour.
- R10: Position code 0 means bottom and code 1 means top, given separately for graphics and video. When a frame start offers both planes the same position, the previous order is kept.
- R11: Configuration inputs have no effect without `frame_start`. The pixel that arrives together with `frame_start` is composed with the newly loaded settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Loads the shadow settings |
| in_valid | input | 1 | Input pixel pair is valid |
| in_gfx | input | 32 | Graphics pixel, ARGB8888 |
| in_vid | input | 32 | Video pixel, ARGB8888 |
| gfx_blend | input | 2 | Graphics alpha source: 0 opaque, 1 global, 2 per pixel |
| gfx_galpha | input | 8 | Graphics global alpha |
| gfx_ksrc | input | 2 | Graphics key source: 0 off, 1 layer beneath, 2 own pixel |
| gfx_key | input | 24 | Graphics colour key, RGB |
| gfx_kmask | input | 24 | Graphics key comparison mask |
| vid_blend | input | 2 | Video alpha source |
| vid_galpha | input | 8 | Video global alpha |
| vid_ksrc | input | 2 | Video key source |
| vid_key | input | 24 | Video colour key |
| vid_kmask | input | 24 | Video key mask |
| gfx_pos | input | 1 | Graphics position: 0 bottom, 1 top |
| vid_pos | input | 1 | Video position: 0 bottom, 1 top |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composited RGB888 pixel |

## Verification
A settings load and a pixel can fall in the same cycle. When they do, the pixel must already see the new blend, key and order settings, while the shadow registers update at that same edge.

The bench provokes this with directed cases and by pulsing `frame_start` at random moments during a random pixel stream. It also keeps changing the configuration inputs between pulses. A reference model judges every output. The model applies a load only on a pulse, applies it to the pixel of that cycle, and refuses equal plane positions.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int CH_W  = 8;
  localparam int N_CH  = 3;
  localparam int RGB_W = CH_W * N_CH;
  localparam int PIX_W = RGB_W + CH_W;

  typedef enum logic [1:0] {BL_OPAQUE = 2'd0, BL_GLOBAL = 2'd1, BL_PIXEL = 2'd2, BL_SPARE = 2'd3} blend_e;
  typedef enum logic [1:0] {KY_OFF = 2'd0, KY_BENEATH = 2'd1, KY_SELF = 2'd2, KY_SPARE = 2'd3} ksrc_e;

  typedef struct packed {
    blend_e             blend;
    logic [CH_W-1:0]    galpha;
    ksrc_e              ksrc;
    logic [RGB_W-1:0]   key;
    logic [RGB_W-1:0]   kmask;
  } plane_cfg_t;
endpackage

// File: rtl/comp_shadow.sv
module comp_shadow
  import comp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  plane_cfg_t new_gfx,
  input  plane_cfg_t new_vid,
  input  logic       new_gpos,
  input  logic       new_vpos,
  output plane_cfg_t eff_gfx,
  output plane_cfg_t eff_vid,
  output logic       eff_gpos,
  output logic       sh_gpos,
  output logic       sh_vpos
);
  localparam plane_cfg_t CFG_RST = '{blend: BL_OPAQUE, galpha: '0, ksrc: KY_OFF, key: '0, kmask: '0};

  plane_cfg_t sh_gfx, sh_vid;
  logic       order_ok;

  assign order_ok = (new_gpos != new_vpos);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_gfx  <= CFG_RST;
      sh_vid  <= CFG_RST;
      sh_gpos <= 1'b0;
      sh_vpos <= 1'b1;
    end else if (load) begin
      sh_gfx <= new_gfx;
      sh_vid <= new_vid;
      if (order_ok) begin
        sh_gpos <= new_gpos;
        sh_vpos <= new_vpos;
      end
    end
  end

  always_comb begin
    eff_gfx  = load ? new_gfx : sh_gfx;
    eff_vid  = load ? new_vid : sh_vid;
    eff_gpos = (load && order_ok) ? new_gpos : sh_gpos;
  end
endmodule

// File: rtl/comp_alpha_sel.sv
module comp_alpha_sel
  import comp_pkg::*;
(
  input  plane_cfg_t        cfg,
  input  logic [PIX_W-1:0]  px,
  input  logic [RGB_W-1:0]  beneath,
  output logic [CH_W-1:0]   alpha
);
  logic [RGB_W-1:0] probe;
  logic             key_on, key_hit;

  always_comb begin
    probe   = (cfg.ksrc == KY_SELF) ? px[RGB_W-1:0] : beneath;
    key_on  = (cfg.ksrc == KY_SELF) || (cfg.ksrc == KY_BENEATH);
    key_hit = key_on && (((probe ^ cfg.key) & cfg.kmask) == '0);
    unique case (cfg.blend)
      BL_GLOBAL: alpha = cfg.galpha;
      BL_PIXEL:  alpha = px[PIX_W-1:RGB_W];
      default:   alpha = '1;
    endcase
    if (key_hit) alpha = '0;
  end
endmodule

// File: rtl/comp_mix.sv
module comp_mix #(
  parameter int CW  = 8,
  parameter int NCH = 3
) (
  input  logic [CW-1:0]     a,
  input  logic [CW*NCH-1:0] fg,
  input  logic [CW*NCH-1:0] bg,
  output logic [CW*NCH-1:0] mix
);
  localparam int            SW   = 2 * CW + 1;
  localparam logic [SW-1:0] MAXV = SW'((1 << CW) - 1);
  localparam logic [SW-1:0] HALF = MAXV >> 1;

  logic [SW-1:0] a_w, ia_w;
  assign a_w  = SW'(a);
  assign ia_w = MAXV - a_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] f_w, b_w, sum, quo;
    always_comb begin
      f_w = SW'(fg[c*CW +: CW]);
      b_w = SW'(bg[c*CW +: CW]);
      sum = a_w * f_w + ia_w * b_w + HALF;
      quo = sum / MAXV;
    end
    assign mix[c*CW +: CW] = quo[CW-1:0];
  end
endmodule

// File: rtl/plane_compositor.sv
module plane_compositor
  import comp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_start,
  input  logic                  in_valid,
  input  logic [PIX_W-1:0]      in_gfx,
  input  logic [PIX_W-1:0]      in_vid,
  input  logic [1:0]            gfx_blend,
  input  logic [CH_W-1:0]       gfx_galpha,
  input  logic [1:0]            gfx_ksrc,
  input  logic [RGB_W-1:0]      gfx_key,
  input  logic [RGB_W-1:0]      gfx_kmask,
  input  logic [1:0]            vid_blend,
  input  logic [CH_W-1:0]       vid_galpha,
  input  logic [1:0]            vid_ksrc,
  input  logic [RGB_W-1:0]      vid_key,
  input  logic [RGB_W-1:0]      vid_kmask,
  input  logic                  gfx_pos,
  input  logic                  vid_pos,
  output logic                  out_valid,
  output logic [RGB_W-1:0]      out_rgb
);
  plane_cfg_t new_gfx, new_vid, eff_gfx, eff_vid;
  logic       eff_gpos, sh_gpos, sh_vpos;

  assign new_gfx = '{blend: blend_e'(gfx_blend), galpha: gfx_galpha, ksrc: ksrc_e'(gfx_ksrc), key: gfx_key, kmask: gfx_kmask};
  assign new_vid = '{blend: blend_e'(vid_blend), galpha: vid_galpha, ksrc: ksrc_e'(vid_ksrc), key: vid_key, kmask: vid_kmask};

  comp_shadow u_shadow (
    .clk(clk), .rst(rst), .load(frame_start),
    .new_gfx(new_gfx), .new_vid(new_vid), .new_gpos(gfx_pos), .new_vpos(vid_pos),
    .eff_gfx(eff_gfx), .eff_vid(eff_vid), .eff_gpos(eff_gpos),
    .sh_gpos(sh_gpos), .sh_vpos(sh_vpos)
  );

  // index 0 = graphics, 1 = video
  plane_cfg_t       p_cfg  [2];
  logic [PIX_W-1:0] p_px   [2];
  logic             p_top  [2];
  logic [CH_W-1:0]  p_alpha[2];

  assign p_cfg[0] = eff_gfx;
  assign p_cfg[1] = eff_vid;
  assign p_px[0]  = in_gfx;
  assign p_px[1]  = in_vid;
  assign p_top[0] = eff_gpos;
  assign p_top[1] = ~eff_gpos;

  for (genvar p = 0; p < 2; p++) begin : g_plane
    logic [RGB_W-1:0] beneath;
    assign beneath = p_top[p] ? p_px[1-p][RGB_W-1:0] : '0;
    comp_alpha_sel u_asel (
      .cfg(p_cfg[p]), .px(p_px[p]), .beneath(beneath), .alpha(p_alpha[p])
    );
  end

  logic [RGB_W-1:0] top_rgb, bot_rgb, bot_mix, fin_mix;
  logic [CH_W-1:0]  a_top, a_bot;

  always_comb begin
    top_rgb = eff_gpos ? in_gfx[RGB_W-1:0] : in_vid[RGB_W-1:0];
    bot_rgb = eff_gpos ? in_vid[RGB_W-1:0] : in_gfx[RGB_W-1:0];
    a_top   = eff_gpos ? p_alpha[0] : p_alpha[1];
    a_bot   = eff_gpos ? p_alpha[1] : p_alpha[0];
  end

  comp_mix #(.CW(CH_W), .NCH(N_CH)) u_mix_bot (
    .a(a_bot), .fg(bot_rgb), .bg('0), .mix(bot_mix)
  );

  logic             s1_v;
  logic [CH_W-1:0]  s1_a_top;
  logic [RGB_W-1:0] s1_top_rgb, s1_bot;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v       <= 1'b0;
      s1_a_top   <= '0;
      s1_top_rgb <= '0;
      s1_bot     <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_a_top   <= a_top;
        s1_top_rgb <= top_rgb;
        s1_bot     <= bot_mix;
      end
    end
  end

  comp_mix #(.CW(CH_W), .NCH(N_CH)) u_mix_top (
    .a(s1_a_top), .fg(s1_top_rgb), .bg(s1_bot), .mix(fin_mix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) out_rgb <= fin_mix;
    end
  end
endmodule

// File: rtl/comp_checker.sv
module comp_checker
  import comp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             in_valid,
  input logic             gfx_pos,
  input logic             vid_pos,
  input logic             sh_gpos,
  input logic             sh_vpos,
  input logic             s1_v,
  input logic [CH_W-1:0]  s1_a_top,
  input logic [RGB_W-1:0] s1_top_rgb,
  input logic [RGB_W-1:0] s1_bot,
  input logic             out_valid,
  input logic [RGB_W-1:0] out_rgb
);
  logic v_d1, v_d2;
  always_ff @(posedge clk) begin
    if (rst) begin
      v_d1 <= 1'b0;
      v_d2 <= 1'b0;
    end else begin
      v_d1 <= in_valid;
      v_d2 <= v_d1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!out_valid && out_rgb == '0));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst) out_valid == v_d2);

  a_r3_opaque_top: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_a_top == '1) |=> out_rgb == $past(s1_top_rgb));

  a_r6_clear_top: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_a_top == '0) |=> out_rgb == $past(s1_bot));

  a_r10_distinct: assert property (@(posedge clk) disable iff (rst) sh_gpos != sh_vpos);

  a_r10_reject: assert property (@(posedge clk) disable iff (rst)
    (frame_start && gfx_pos == vid_pos) |=> $stable({sh_gpos, sh_vpos}));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable({sh_gpos, sh_vpos}));
endmodule

bind plane_compositor comp_checker i_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .in_valid(in_valid),
  .gfx_pos(gfx_pos), .vid_pos(vid_pos), .sh_gpos(sh_gpos), .sh_vpos(sh_vpos),
  .s1_v(s1_v), .s1_a_top(s1_a_top), .s1_top_rgb(s1_top_rgb), .s1_bot(s1_bot),
  .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/test_plane_compositor.sv
`timescale 1ns/1ps
module test_plane_compositor;
  logic clk = 1'b0;
  logic rst, fs, iv;
  logic [31:0] gpx, vpx;
  logic [1:0]  gbl, vbl, gks, vks;
  logic [7:0]  gga, vga;
  logic [23:0] gky, vky, gmk, vmk;
  logic        gpo, vpo;
  logic        ov;
  logic [23:0] orgb;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  plane_compositor i_plane_compositor (
    .clk(clk), .rst(rst), .frame_start(fs), .in_valid(iv), .in_gfx(gpx), .in_vid(vpx),
    .gfx_blend(gbl), .gfx_galpha(gga), .gfx_ksrc(gks), .gfx_key(gky), .gfx_kmask(gmk),
    .vid_blend(vbl), .vid_galpha(vga), .vid_ksrc(vks), .vid_key(vky), .vid_kmask(vmk),
    .gfx_pos(gpo), .vid_pos(vpo), .out_valid(ov), .out_rgb(orgb)
  );

  // reference model state
  logic [1:0]  m_gbl, m_vbl, m_gks, m_vks;
  logic [7:0]  m_gga, m_vga;
  logic [23:0] m_gky, m_vky, m_gmk, m_vmk;
  logic        m_gtop;

  logic        have_prev, p_v;
  logic [23:0] p_rgb;
  string       p_tag;

  function automatic logic [7:0] f_alpha(logic [1:0] bl, logic [7:0] ga, logic [1:0] ks,
                                         logic [23:0] ky, logic [23:0] mk,
                                         logic [31:0] px, logic [23:0] low);
    logic [23:0] src;
    src = (ks == 2'd2) ? px[23:0] : low;
    if ((ks == 2'd1 || ks == 2'd2) && (((src ^ ky) & mk) == 24'h0)) return 8'd0;
    if (bl == 2'd1) return ga;
    if (bl == 2'd2) return px[31:24];
    return 8'd255;
  endfunction

  function automatic logic [23:0] f_mix(logic [7:0] a, logic [23:0] f, logic [23:0] b);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) begin
      int v;
      v = (int'(a) * int'(f[c*8 +: 8]) + (255 - int'(a)) * int'(b[c*8 +: 8]) + 127) / 255;
      r[c*8 +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic logic [23:0] f_expect(logic [31:0] g, logic [31:0] v);
    logic [7:0] at, ab;
    if (m_gtop) begin
      ab = f_alpha(m_vbl, m_vga, m_vks, m_vky, m_vmk, v, 24'h0);
      at = f_alpha(m_gbl, m_gga, m_gks, m_gky, m_gmk, g, v[23:0]);
      return f_mix(at, g[23:0], f_mix(ab, v[23:0], 24'h0));
    end
    ab = f_alpha(m_gbl, m_gga, m_gks, m_gky, m_gmk, g, 24'h0);
    at = f_alpha(m_vbl, m_vga, m_vks, m_vky, m_vmk, v, g[23:0]);
    return f_mix(at, v[23:0], f_mix(ab, g[23:0], 24'h0));
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic        ev;
    logic [23:0] e;
    if (fs) begin
      m_gbl = gbl; m_gga = gga; m_gks = gks; m_gky = gky; m_gmk = gmk;
      m_vbl = vbl; m_vga = vga; m_vks = vks; m_vky = vky; m_vmk = vmk;
      if (gpo != vpo) m_gtop = gpo;
    end
    ev = iv;
    e  = f_expect(gpx, vpx);
    @(posedge clk);
    @(negedge clk);
    if (have_prev) begin
      chk(p_tag, "out_valid", {31'b0, ov}, {31'b0, p_v});
      if (p_v) chk(p_tag, "out_rgb", {8'h0, orgb}, {8'h0, p_rgb});
    end
    p_v = ev; p_rgb = e; p_tag = tag; have_prev = 1'b1;
  endtask

  task automatic fstep(string tag);
    fs = 1'b1;
    step(tag);
    fs = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; fs = 1'b0; iv = 1'b0; gpx = '0; vpx = '0;
    gbl = 0; vbl = 0; gks = 0; vks = 0; gga = 0; vga = 0;
    gky = 0; vky = 0; gmk = 0; vmk = 0; gpo = 1'b0; vpo = 1'b1;
    m_gbl = 0; m_vbl = 0; m_gks = 0; m_vks = 0; m_gga = 0; m_vga = 0;
    m_gky = 0; m_vky = 0; m_gmk = 0; m_vmk = 0; m_gtop = 1'b0;
    have_prev = 1'b0; p_v = 1'b0; p_rgb = '0; p_tag = "";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset out_valid", {31'b0, ov}, 32'h0);
    chk("R1", "reset out_rgb", {8'h0, orgb}, 32'h0);
    rst = 1'b0;

    // R1/R3: defaults after reset, video opaque on top
    iv = 1'b1; gpx = 32'h11_203040; vpx = 32'h80_A0B0C0;
    step("R1");
    gpx = 32'h00_FFFFFF; vpx = 32'h00_010203;
    step("R3");
    iv = 1'b0;
    step("R2");
    chk("R1", "literal video pixel", {8'h0, orgb}, 32'h00_010203);

    // R4: video global alpha 128 over black graphics
    vbl = 2'd1; vga = 8'd128; iv = 1'b1; gpx = 32'h00_000000; vpx = 32'h00_FFFFFF;
    fstep("R4");
    step("R4");
    step("R2");
    chk("R4", "literal half blend", {8'h0, orgb}, 32'h00_808080);
    vpx = 32'h00_40C020; gpx = 32'h00_102030;
    step("R4");

    // R5: per-pixel alpha on video, global on graphics
    vbl = 2'd2; gbl = 2'd1; gga = 8'd200;
    vpx = 32'h00_FF0000; gpx = 32'hFF_00FF00;
    fstep("R5");
    vpx = 32'hFF_FF0000; step("R5");
    vpx = 32'h7F_12345A; step("R5");
    gbl = 2'd3; vbl = 2'd3;
    fstep("R3");

    // R10: graphics on top; then an equal-position request is refused
    gbl = 2'd2; vbl = 2'd0; gpo = 1'b1; vpo = 1'b0;
    gpx = 32'h40_FFFFFF; vpx = 32'hFF_204060;
    fstep("R10");
    step("R10");
    gpo = 1'b1; vpo = 1'b1;
    fstep("R10");
    gpo = 1'b0; vpo = 1'b0;
    fstep("R10");
    step("R10");

    // R7/R9: graphics (top) keyed on its own colour with a partial mask
    gpo = 1'b1; vpo = 1'b0; gbl = 2'd0;
    gks = 2'd2; gky = 24'h123456; gmk = 24'hFF00FF;
    gpx = 32'hFF_12AB56; vpx = 32'hFF_334455;
    fstep("R7");
    gpx = 32'hFF_13AB56; step("R9");
    gmk = 24'h000000; gpx = 32'hFF_FEDCBA;
    fstep("R9");

    // R8: top keyed on the layer beneath; bottom keyed against black
    gks = 2'd1; gky = 24'hABCDEF; gmk = 24'hFFFFFF;
    gpx = 32'hFF_777777; vpx = 32'hFF_ABCDEF;
    fstep("R8");
    vpx = 32'hFF_ABCDEE; step("R8");
    gks = 2'd3; vks = 2'd1; vky = 24'h000000; vmk = 24'hFFFFFF; gbl = 2'd1; gga = 8'd100;
    fstep("R8");
    vks = 2'd2; vky = 24'h000000; vmk = 24'h0000FF;
    vpx = 32'hFF_ABCD00;
    fstep("R8");

    // R11: changes without frame_start are ignored; same-cycle load applies
    gbl = 2'd0; gks = 2'd0; vks = 2'd0; gpo = 1'b0; vpo = 1'b1;
    step("R11");
    step("R11");
    vbl = 2'd1; vga = 8'd10;
    fstep("R11");
    step("R11");

    // R6/R2: random stream with random loads
    for (int i = 0; i < 3000; i++) begin
      iv  = ($urandom % 4) != 0;
      fs  = ($urandom % 20) == 0;
      gbl = 2'($urandom); vbl = 2'($urandom); gks = 2'($urandom); vks = 2'($urandom);
      gga = 8'($urandom); vga = 8'($urandom);
      gky = 24'($urandom); vky = 24'($urandom);
      gmk = (($urandom % 2) != 0) ? 24'($urandom) & 24'h0F0F0F : 24'($urandom);
      vmk = (($urandom % 2) != 0) ? 24'h0000FF : 24'($urandom);
      gpo = 1'($urandom); vpo = 1'($urandom);
      gpx = 32'($urandom); vpx = 32'($urandom);
      if ($urandom % 4 == 0) gpx[23:0] = m_gky;
      if ($urandom % 4 == 0) vpx[23:0] = m_vky;
      if ($urandom % 6 == 0) vpx[23:0] = gpx[23:0];
      step("R6");
    end
    fs = 1'b0; iv = 1'b0;
    step("R2");
    step("R2");
    summary();
    $finish;
  end
endmodule